// File: doc/BRIEF.md
# Instruction Subset Guard with Sticky Trap

This block sits next to the decode stage of a small 32-bit RISC-V core and judges every fetched instruction word against a reduced instruction subset. The subset is the base integer set (computation, loads, stores, branches and jumps), the 16-bit compressed encodings that map onto it, and the multiply half of the multiply/divide extension. Division, every SYSTEM-opcode instruction (CSR access, ECALL, EBREAK, MRET, WFI), memory-ordering instructions and every other opcode are rejected.

When a word presented with the valid strobe falls outside the subset, the block raises a combinational flag in that cycle. On the following clock edge it latches a halt that stalls the core. The halt is sticky: no later instruction, strobe or input pattern clears it. Only the synchronous active-low reset does. While halted, the block blinks the red channel of an RGB status LED from a parameterised divider and holds green and blue dark. The LED is fully dark while the core runs. The block has no interrupt inputs and no interrupt logic.

Top module: `insn_guard`

## Requirements
- R1: A word whose bits [1:0] are not 11 is judged as a 16-bit compressed instruction from bits [15:0], using quadrant bits [1:0] and function bits [15:13]. The following are illegal: the all-zero halfword; C.ADDI4SPN with a zero immediate in bits [12:5]; every floating-point load or store form; the reserved quadrant-0 slot 100; C.ADDI16SP or C.LUI with a zero immediate in {bit 12, bits [6:2]}; C.SRLI, C.SRAI and C.SLLI with bit 12 set; the quadrant-1 register-register group with bit 12 set; C.LWSP with rd zero; C.JR with rs1 zero; and C.EBREAK (halfword 0x9002). All other compressed forms are legal.
- R2: A 32-bit word (bits [1:0] = 11) is legal in the following cases. LUI, AUIPC and JAL are legal. JALR is legal with funct3 000. A branch is legal with any funct3 except 010 and 011. A load is legal with funct3 000, 001, 010, 100 or 101. A store is legal with funct3 000, 001 or 010. OP-IMM is legal except that SLLI needs funct7 0000000 and SRLI/SRAI need funct7 0000000 or 0100000. OP is legal with funct7 0000000 for any funct3, or with funct7 0100000 and funct3 000 or 101.
- R3: With opcode OP (0110011) and funct7 0000001, funct3 000 to 011 (the multiply forms) is legal and funct3 100 to 111 (the divide and remainder forms) is illegal.
- R4: Every word with opcode 1110011 (SYSTEM) or 0001111 (memory ordering) is illegal, and so is every 32-bit opcode not named in R2.
- R5: illegal_o equals insn_vld_i AND NOT legal in the same cycle. When insn_vld_i is low, illegal_o is low and an illegal word does not set the halt.
- R6: halt_o rises on the clock edge that ends a cycle with illegal_o high. After that it stays high for every later cycle, whatever words or strobes are applied.
- R7: rst_n sampled low on a rising clock edge clears halt_o and darkens the LED. After reset the block runs again.
- R8: While halted, in the j-th halted cycle (j = 0 in the first cycle halt_o is high), led_r_o is high exactly when bit BLINK_LOG2 of j is 0. led_g_o and led_b_o are low.
- R9: While not halted, led_r_o, led_g_o and led_b_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_i | input | 32 | Fetched instruction word; compressed forms in bits [15:0] |
| insn_vld_i | input | 1 | Qualifies insn_i for checking |
| illegal_o | output | 1 | Current valid word lies outside the subset |
| halt_o | output | 1 | Sticky halt request to the core |
| led_r_o | output | 1 | Red LED drive, blinking while halted |
| led_g_o | output | 1 | Green LED drive, held low |
| led_b_o | output | 1 | Blue LED drive, held low |

## Verification
Two functions can act in the same cycle: the legality flag for a fresh word and the blink sequencer running from an earlier halt. After a halt, the bench keeps presenting random legal and illegal words with the strobe toggling. In each cycle it judges illegal_o against its own subset model and the red channel against the cycle count since the halting edge. New illegal detections must neither restart nor disturb the blink phase. A second overlap is reset in the same cycle as an illegal word. Reset must win, and the halt must stay clear on the edge that follows.

// File: rtl/insn_guard_pkg.sv
// Package: shared opcode constants and the field view of a 32-bit word.
// Assumes the standard RV32 major opcode positions (bits [6:0]).
package insn_guard_pkg;

    localparam logic [6:0] OPC_LUI    = 7'b0110111;
    localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [6:0] OPC_OP     = 7'b0110011;

    localparam logic [6:0] F7_BASE    = 7'b0000000;
    localparam logic [6:0] F7_ALT     = 7'b0100000;
    localparam logic [6:0] F7_MULDIV  = 7'b0000001;

    // Fields the 32-bit legality decode looks at.
    typedef struct packed {
        logic [6:0] f7;
        logic [2:0] f3;
        logic [6:0] opc;
    } rv_fields_t;

    // Quadrant codes of a compressed halfword.
    typedef enum logic [1:0] {
        CQ_0   = 2'b00,
        CQ_1   = 2'b01,
        CQ_2   = 2'b10,
        CQ_W32 = 2'b11
    } cquad_e;

    function automatic rv_fields_t split_fields(input logic [31:0] w);
        rv_fields_t f;
        f.f7  = w[31:25];
        f.f3  = w[14:12];
        f.opc = w[6:0];
        return f;
    endfunction

endpackage

// File: rtl/insn_guard_dec32.sv
// Module: insn_guard_dec32
// Judges a 32-bit word against the accepted base integer plus multiply subset.
// Assumes the caller has already decided that the word is 32 bits wide.
// Purely combinational.
module insn_guard_dec32
    import insn_guard_pkg::*;
(
    input  rv_fields_t fld_i,
    output logic       legal_o
);

    logic op_legal;
    logic opimm_legal;

    // Register-register group: base ALU, alternate SUB/SRA, multiply only.
    always_comb begin
        unique case (fld_i.f7)
            F7_BASE:   op_legal = 1'b1;
            F7_ALT:    op_legal = (fld_i.f3 == 3'b000) || (fld_i.f3 == 3'b101);
            F7_MULDIV: op_legal = ~fld_i.f3[2];
            default:   op_legal = 1'b0;
        endcase
    end

    // Immediate ALU group: only shift forms constrain the upper bits.
    always_comb begin
        unique case (fld_i.f3)
            3'b001:  opimm_legal = (fld_i.f7 == F7_BASE);
            3'b101:  opimm_legal = (fld_i.f7 == F7_BASE) || (fld_i.f7 == F7_ALT);
            default: opimm_legal = 1'b1;
        endcase
    end

    // Major opcode selection; anything not listed is outside the subset.
    always_comb begin
        unique case (fld_i.opc)
            OPC_LUI, OPC_AUIPC, OPC_JAL: legal_o = 1'b1;
            OPC_JALR:   legal_o = (fld_i.f3 == 3'b000);
            OPC_BRANCH: legal_o = (fld_i.f3[2:1] != 2'b01);
            OPC_LOAD:   legal_o = (fld_i.f3 != 3'b011) && (fld_i.f3[2:1] != 2'b11);
            OPC_STORE:  legal_o = ~fld_i.f3[2] && (fld_i.f3 != 3'b011);
            OPC_OPIMM:  legal_o = opimm_legal;
            OPC_OP:     legal_o = op_legal;
            default:    legal_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/insn_guard_dec16.sv
// Module: insn_guard_dec16
// Judges a 16-bit compressed halfword for a 32-bit integer-only core.
// Floating-point compressed forms, reserved slots, zero immediates that
// are reserved, RV64-only forms and the breakpoint form are rejected.
// Assumes bits [1:0] of the halfword are not 11. Purely combinational.
module insn_guard_dec16
    import insn_guard_pkg::*;
(
    input  logic [15:0] hw_i,
    output logic        legal_o
);

    cquad_e     quad;
    logic [2:0] fn3;
    logic [4:0] rd;
    logic [4:0] rs2;
    logic       b12;
    logic       imm6_nz;
    logic       q0_legal;
    logic       q1_legal;
    logic       q2_legal;

    // Field extraction shared by the three quadrant decodes.
    always_comb begin
        quad    = cquad_e'(hw_i[1:0]);
        fn3     = hw_i[15:13];
        rd      = hw_i[11:7];
        rs2     = hw_i[6:2];
        b12     = hw_i[12];
        imm6_nz = b12 || (rs2 != 5'd0);
    end

    // Quadrant 0: stack-relative address form and word loads/stores only.
    always_comb begin
        unique case (fn3)
            3'b000:         q0_legal = (hw_i[12:5] != 8'd0);
            3'b010, 3'b110: q0_legal = 1'b1;
            default:        q0_legal = 1'b0;
        endcase
    end

    // Quadrant 1: immediates, jumps, branches and the arithmetic group.
    always_comb begin
        unique case (fn3)
            3'b011: q1_legal = imm6_nz;
            3'b100: q1_legal = (hw_i[11:10] == 2'b10) ? 1'b1 : ~b12;
            default: q1_legal = 1'b1;
        endcase
    end

    // Quadrant 2: left shift, stack loads/stores, jumps, moves and adds.
    always_comb begin
        unique case (fn3)
            3'b000: q2_legal = ~b12;
            3'b010: q2_legal = (rd != 5'd0);
            3'b100: begin
                if (rs2 != 5'd0)
                    q2_legal = 1'b1;
                else
                    q2_legal = (rd != 5'd0);
            end
            3'b110: q2_legal = 1'b1;
            default: q2_legal = 1'b0;
        endcase
    end

    // Quadrant select.
    always_comb begin
        unique case (quad)
            CQ_0:    legal_o = q0_legal;
            CQ_1:    legal_o = q1_legal;
            CQ_2:    legal_o = q2_legal;
            default: legal_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/insn_guard_trap.sv
// Module: insn_guard_trap
// Sticky halt flop: sets on a request and clears only through reset.
// Assumes a synchronous active-low reset.
module insn_guard_trap (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    output logic halt_o
);

    // Halt state: once set, held until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            halt_o <= 1'b0;
        else if (set_i)
            halt_o <= 1'b1;
    end

endmodule

// File: rtl/insn_guard_blink.sv
// Module: insn_guard_blink
// Drives the RGB status LED. Dark while running. While halted, red
// alternates every 2**BLINK_LOG2 cycles, starting lit. Green and blue
// stay dark. Assumes run_i rises once per halt episode.
module insn_guard_blink #(
    parameter int unsigned BLINK_LOG2 = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic led_r_o,
    output logic led_g_o,
    output logic led_b_o
);

    localparam int unsigned CW = BLINK_LOG2 + 1;

    logic [CW-1:0] phase_q;

    // Phase counter: held at zero until halted, then free-running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    // LED drive from the halt state and the top phase bit.
    always_comb begin
        led_r_o = run_i && !phase_q[CW-1];
        led_g_o = 1'b0;
        led_b_o = 1'b0;
    end

endmodule

// File: rtl/insn_guard.sv
// Module: insn_guard (top)
// Checks each strobed instruction word against the accepted subset. It
// flags violations in the same cycle and latches a sticky halt on the
// next edge. It blinks a red LED while halted. Assumes the core stalls on
// halt_o and that only the synchronous active-low reset ends a halt.
module insn_guard
    import insn_guard_pkg::*;
#(
    parameter int unsigned BLINK_LOG2 = 22
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] insn_i,
    input  logic        insn_vld_i,
    output logic        illegal_o,
    output logic        halt_o,
    output logic        led_r_o,
    output logic        led_g_o,
    output logic        led_b_o
);

    rv_fields_t fld;
    logic       is_w32;
    logic       legal32;
    logic       legal16;
    logic       unused_imm_bits;

    // Word width and field split.
    always_comb begin
        fld             = split_fields(insn_i);
        is_w32          = (insn_i[1:0] == 2'b11);
        unused_imm_bits = ^insn_i[24:16];
    end

    insn_guard_dec32 u_dec32 (
        .fld_i   (fld),
        .legal_o (legal32)
    );

    insn_guard_dec16 u_dec16 (
        .hw_i    (insn_i[15:0]),
        .legal_o (legal16)
    );

    // Violation flag for the current strobed word.
    always_comb begin
        illegal_o = insn_vld_i && !(is_w32 ? legal32 : legal16);
    end

    insn_guard_trap u_trap (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (illegal_o),
        .halt_o (halt_o)
    );

    insn_guard_blink #(
        .BLINK_LOG2 (BLINK_LOG2)
    ) u_blink (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (halt_o),
        .led_r_o (led_r_o),
        .led_g_o (led_g_o),
        .led_b_o (led_b_o)
    );

endmodule

// File: rtl/insn_guard_chk.sv
// Module: insn_guard_chk
// Property checker for insn_guard, attached through bind.
module insn_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [6:0] opc,
    input logic [2:0] f3,
    input logic [6:0] f7,
    input logic       insn_vld_i,
    input logic       illegal_o,
    input logic       halt_o,
    input logic       led_r_o,
    input logic       led_g_o,
    input logic       led_b_o
);

    p_div_rejected_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_vld_i && opc == 7'b0110011 && f7 == 7'b0000001 && f3[2]) |-> illegal_o);

    p_system_rejected_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_vld_i && (opc == 7'b1110011 || opc == 7'b0001111)) |-> illegal_o);

    p_flag_needs_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_vld_i |-> !illegal_o);

    p_halt_follows_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |=> halt_o);

    p_halt_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> halt_o);

    p_halt_has_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_o) |-> $past(illegal_o));

    p_reset_clears_r7: assert property (@(posedge clk)
        !rst_n |=> !halt_o);

    p_red_lit_on_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_o) |-> led_r_o);

    p_only_red_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |-> (!led_g_o && !led_b_o));

    p_dark_running_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !halt_o |-> (!led_r_o && !led_g_o && !led_b_o));

endmodule

bind insn_guard insn_guard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .opc        (insn_i[6:0]),
    .f3         (insn_i[14:12]),
    .f7         (insn_i[31:25]),
    .insn_vld_i (insn_vld_i),
    .illegal_o  (illegal_o),
    .halt_o     (halt_o),
    .led_r_o    (led_r_o),
    .led_g_o    (led_g_o),
    .led_b_o    (led_b_o)
);

// File: tb/insn_guard_tb.sv
module insn_guard_tb;

    localparam int CLK_PERIOD = 10;
    localparam int BL = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn = 32'h0;
    logic        vld = 1'b0;
    logic        illegal, halt, lr, lg, lb;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    insn_guard #(.BLINK_LOG2(BL)) u_dut (
        .clk (clk), .rst_n (rst_n), .insn_i (insn), .insn_vld_i (vld),
        .illegal_o (illegal), .halt_o (halt),
        .led_r_o (lr), .led_g_o (lg), .led_b_o (lb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (insn %08h)", req, act, exp, insn);
        end
    endtask

    // Model of the compressed subset (R1).
    function automatic bit ref_c(input logic [15:0] h);
        logic [2:0] f = h[15:13];
        logic [4:0] rd = h[11:7];
        logic [4:0] r2 = h[6:2];
        case (h[1:0])
            2'b00: return (f == 3'd0) ? (h[12:5] != 0) : (f == 3'd2 || f == 3'd6);
            2'b01: begin
                if (f == 3'd3) return (h[12] || r2 != 0);
                if (f == 3'd4) return (h[11:10] == 2'b10) || !h[12];
                return 1'b1;
            end
            2'b10: begin
                if (f == 3'd0) return !h[12];
                if (f == 3'd2) return rd != 0;
                if (f == 3'd6) return 1'b1;
                if (f == 3'd4) return (r2 != 0) || (rd != 0);
                return 1'b0;
            end
            default: return 1'b0;
        endcase
    endfunction

    // Model of the full subset (R1-R4 individually).
    function automatic bit ref_legal(input logic [31:0] w);
        logic [2:0] f3 = w[14:12];
        logic [6:0] f7 = w[31:25];
        if (w[1:0] != 2'b11) return ref_c(w[15:0]);
        case (w[6:0])
            7'h37, 7'h17, 7'h6f: return 1'b1;
            7'h67: return f3 == 0;
            7'h63: return !(f3 == 2 || f3 == 3);
            7'h03: return f3 == 0 || f3 == 1 || f3 == 2 || f3 == 4 || f3 == 5;
            7'h23: return f3 <= 2;
            7'h13: begin
                if (f3 == 1) return f7 == 0;
                if (f3 == 5) return f7 == 0 || f7 == 7'h20;
                return 1'b1;
            end
            7'h33: begin
                if (f7 == 0) return 1'b1;
                if (f7 == 7'h20) return f3 == 0 || f3 == 5;
                if (f7 == 7'h01) return f3 < 4;
                return 1'b0;
            end
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] mk(input logic [6:0] f7, input logic [2:0] f3,
                                       input logic [6:0] opc);
        return {f7, 5'd3, 5'd2, f3, 5'd1, opc};
    endfunction

    function automatic string tag_of(input logic [31:0] w);
        if (w[1:0] != 2'b11) return "R1";
        if (w[6:0] == 7'h33 && w[31:25] == 7'h01) return "R3";
        if (w[6:0] == 7'h73 || w[6:0] == 7'h0f) return "R4";
        return "R2";
    endfunction

    // Drive one word at the negedge; the flag is combinational (R5).
    task automatic apply(input logic [31:0] w, input bit v);
        @(negedge clk);
        insn = w;
        vld  = v;
        #1;
        check(illegal == (v && !ref_legal(w)), v ? tag_of(w) : "R5",
              illegal, v && !ref_legal(w));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        vld   = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    logic [31:0] dir [] = '{
        32'h0000_0000, 32'h0000_0001, 32'h0000_9002, 32'h0000_8002, 32'h0000_4002,
        32'h0000_6101, 32'h0000_6505, 32'h0000_9001, 32'h0000_2000, 32'h0000_4000,
        32'h0000_1002, 32'h0000_8082, 32'h0000_9082, 32'h0000_8c05, 32'h0000_9c05,
        32'h0000_0040, 32'h0000_0073, 32'h0010_0073, 32'h3020_0073, 32'h1050_0073,
        32'h3410_2573, 32'h0ff0_000f, 32'h0000_100f, 32'h0000_002f, 32'h0000_0007,
        32'h1234_5037, 32'h0000_0017, 32'h0000_006f };

    logic [6:0] opcs [11] = '{7'h37, 7'h17, 7'h6f, 7'h67, 7'h63, 7'h03, 7'h23,
                              7'h13, 7'h33, 7'h73, 7'h0f};

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        do_reset();
        @(negedge clk);
        // R7, R9: state after reset
        check(halt == 0, "R7", halt, 0);
        check({lr, lg, lb} == 0, "R9", {lr, lg, lb}, 0);

        // R5: strobe low ignores an illegal word; halt stays clear
        apply(32'h0000_0073, 1'b0);
        apply(32'h0000_0000, 1'b0);
        @(negedge clk);
        check(halt == 0, "R5", halt, 0);

        // R2, R9: legal run keeps halt clear and LED dark
        apply(mk(7'h00, 3'd0, 7'h33), 1'b1);
        apply(mk(7'h20, 3'd5, 7'h13), 1'b1);
        apply(32'h0000_4000, 1'b1);
        @(negedge clk);
        check(halt == 0, "R2", halt, 0);
        check(lr == 0, "R9", lr, 0);

        // Directed sweeps R1-R4 (flag is independent of halt)
        foreach (dir[i]) apply(dir[i], 1'b1);
        for (int f = 0; f < 8; f++) apply(mk(7'h01, f[2:0], 7'h33), 1'b1);  // R3
        for (int f = 0; f < 8; f++) apply(mk(7'h20, f[2:0], 7'h33), 1'b1);  // R2
        for (int f = 0; f < 8; f++) begin
            apply(mk(7'h00, f[2:0], 7'h13), 1'b1);
            apply(mk(7'h20, f[2:0], 7'h13), 1'b1);
            apply(mk(7'h00, f[2:0], 7'h67), 1'b1);
            apply(mk(7'h00, f[2:0], 7'h63), 1'b1);
            apply(mk(7'h00, f[2:0], 7'h03), 1'b1);
            apply(mk(7'h00, f[2:0], 7'h23), 1'b1);
            apply(mk(7'h00, f[2:0], 7'h73), 1'b1);                          // R4
        end

        // Constrained random over all forms
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] w = $urandom;
            int m = $urandom_range(0, 3);
            if (m == 1) w = {w[31:7], opcs[$urandom_range(0, 10)]};
            else if (m == 2) w[1:0] = 2'($urandom_range(0, 2));
            else if (m == 3) begin
                logic [6:0] sel [4] = '{7'h00, 7'h20, 7'h01, 7'h7f};
                w = {sel[$urandom_range(0, 3)], w[24:7], 7'h33};
            end
            apply(w, ($urandom_range(0, 7) != 0));
        end

        // Halt and blink: R6, R8
        do_reset();
        apply(mk(7'h01, 3'd0, 7'h33), 1'b1);
        apply(32'h0000_0001, 1'b1);
        @(negedge clk);
        check(halt == 0, "R6", halt, 0);
        apply(mk(7'h01, 3'd4, 7'h33), 1'b1);  // DIV: halts on next edge
        for (int j = 0; j < 60; j++) begin
            logic [31:0] w = $urandom;
            @(negedge clk);
            check(halt == 1, "R6", halt, 1);
            check(lr == (((j >> BL) & 1) == 0), "R8", lr, ((j >> BL) & 1) == 0);
            check({lg, lb} == 0, "R8", {lg, lb}, 0);
            insn = w;
            vld  = $urandom_range(0, 1);
            #1;
            check(illegal == (vld && !ref_legal(w)), tag_of(w), illegal,
                  vld && !ref_legal(w));
        end
        vld = 1'b0;
        repeat (150) @(negedge clk);
        check(halt == 1, "R6", halt, 1);

        // R7: reset in the same cycle as an illegal word wins
        insn  = 32'h0000_0000;
        vld   = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check(halt == 0, "R7", halt, 0);
        check({lr, lg, lb} == 0, "R7", {lr, lg, lb}, 0);
        vld   = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(halt == 0, "R7", halt, 0);

        // Compressed illegal right after reset halts too (R1, R6, R8)
        apply(32'h0000_9002, 1'b1);
        @(negedge clk);
        vld = 1'b0;
        check(halt == 1, "R6", halt, 1);
        check(lr == 1, "R8", lr, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule